// File: doc/BRIEF.md
# Address Breakpoint Comparator

This block watches a processor's 16-bit address bus and raises a break request when a programmed address appears. Software loads the target address through two byte-wide registers and uses a control byte to arm the comparison. Whenever the unit is armed and a qualified bus address equals the target, a sticky active flag is set. A level break interrupt request is driven toward the core for as long as that flag stays set.

Software can also force a break by writing 1 to the active flag. The break handler clears the flag by writing 0 to it before it returns. If a hardware match and a software clear land on the same cycle, the match wins.

Register access uses a small 8-bit bus with a 2-bit offset, a write strobe and a read strobe. Reads are combinational. Writes take effect on the clock edge. Register map:

| Offset | Contents |
|---|---|
| 0 | Target address bits 15..8 |
| 1 | Target address bits 7..0 |
| 2 | Control byte |
| 3 | Unmapped |

Top module: `brk_unit`

## Requirements
- R1: After reset, both target bytes, the arm bit and the active flag are 0. Every register read returns 0 and `brk_irq` is low.
- R2: Offset 0 holds target bits 15..8 and offset 1 holds target bits 7..0. Each byte reads back the last value written to it.
- R3: Reading offset 2 returns the arm bit in bit 7 and the active flag in bit 6. Bits 5..0 always read 0, whatever was written to them.
- R4: The active flag is set at the clock edge that ends a cycle in which the arm bit is 1, `cpu_valid` is 1 and `cpu_addr` equals the full 16-bit target.
- R5: While the arm bit is 0, an address equal to the target leaves the active flag unchanged.
- R6: A cycle with `cpu_valid` low never sets the active flag, even when the address matches.
- R7: An address that differs from the target in any single bit does not set the active flag.
- R8: Writing offset 2 with bit 6 = 1 sets the active flag.
- R9: Only a write of 0 to bit 6 of offset 2 clears the active flag. Once set, the flag stays set across later non-matching bus cycles.
- R10: A hardware match and a software clear of the active flag on the same cycle leave the flag set.
- R11: Reading offset 3 returns 0. Writing offset 3 changes no register and does not change `brk_irq`.
- R12: `brk_irq` equals the active flag at all times.
- R13: While `rd_en` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised to `clk` inside the block. |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 8 | Register read data. Combinational; 0 when `rd_en` is low. |
| cpu_addr | input | 16 | Monitored processor address |
| cpu_valid | input | 1 | Qualifier for `cpu_addr` |
| brk_irq | output | 1 | Level break interrupt request |

## Verification
Timing of each result:
- Read data is combinational. It is due in the same cycle as the read strobe.
- A register write becomes visible after the next rising edge.
- `brk_irq` changes after exactly one rising edge following the bus cycle or control write that caused the change.

The bench drives every stimulus on a falling edge. It samples reads two nanoseconds later. It samples write and match results at the following falling edge, which puts exactly one rising edge between stimulus and check. The match sweep applies every single-bit neighbour of several targets before applying the exact address, so a premature or wrong set shows up on the very cycle it happens.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Control state kept by the breakpoint unit
  typedef struct packed {
    logic en;   // comparison armed
    logic act;  // break active (sticky)
  } brk_ctrl_t;

endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/brk_addr_regs.sv
module brk_addr_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] tgt_o
);

  localparam int unsigned NB = ADDR_W / DATA_W;

  // Byte lane k is reached at offset NB-1-k (most significant byte first)
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam logic [RAW-1:0] LANE_OFF = RAW'(NB - 1 - k);

    logic              ld;
    logic [DATA_W-1:0] byte_d;
    logic [DATA_W-1:0] byte_q;

    assign ld = wr_en && (wr_addr == LANE_OFF);

    always_comb begin
      byte_d = byte_q;
      if (ld) begin
        byte_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else begin
        byte_q <= byte_d;
      end
    end

    assign tgt_o[k*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] tgt,
  output logic              hit_o
);

  localparam int unsigned NB = ADDR_W / DATA_W;

  logic [NB-1:0] lane_eq;

  // Per-lane equality, reduced with an AND tree
  for (genvar k = 0; k < NB; k++) begin : g_eq
    assign lane_eq[k] = (cpu_addr[k*DATA_W +: DATA_W] == tgt[k*DATA_W +: DATA_W]);
  end

  assign hit_o = cpu_valid && (&lane_eq);

endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_wr,
  input  logic      wr_en_bit,
  input  logic      wr_act_bit,
  input  logic      hit,
  output brk_ctrl_t st_o
);

  brk_ctrl_t st_d;
  brk_ctrl_t st_q;

  always_comb begin
    st_d = st_q;
    if (ctl_wr) begin
      st_d.en  = wr_en_bit;
      st_d.act = wr_act_bit;
    end
    // Armed hardware match takes priority over a software clear
    if (hit && st_q.en) begin
      st_d.act = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [RAW-1:0]    rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_valid,
  output logic              brk_irq
);

  localparam int unsigned NB = ADDR_W / DATA_W;
  localparam logic [RAW-1:0] CTRL_OFF = RAW'(NB);
  localparam int unsigned EN_POS  = DATA_W - 1;
  localparam int unsigned ACT_POS = DATA_W - 2;

  logic              rst_q_n;
  logic [ADDR_W-1:0] tgt_addr;
  logic              addr_hit;
  logic              ctl_wr;
  brk_ctrl_t         ctrl_st;
  logic              en_q;
  logic              act_q;
  logic [DATA_W-1:0] rd_mux;

  brk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_q_n)
  );

  brk_addr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW(RAW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .tgt_o  (tgt_addr)
  );

  brk_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .cpu_addr (cpu_addr),
    .cpu_valid(cpu_valid),
    .tgt      (tgt_addr),
    .hit_o    (addr_hit)
  );

  assign ctl_wr = wr_en && (wr_addr == CTRL_OFF);

  brk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ctl_wr    (ctl_wr),
    .wr_en_bit (wr_data[EN_POS]),
    .wr_act_bit(wr_data[ACT_POS]),
    .hit       (addr_hit),
    .st_o      (ctrl_st)
  );

  assign en_q  = ctrl_st.en;
  assign act_q = ctrl_st.act;

  // Read multiplexer: target lanes, control byte, everything else zero
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < int'(NB); k++) begin
      if (rd_addr == RAW'(NB - 1 - k)) begin
        rd_mux = tgt_addr[k*DATA_W +: DATA_W];
      end
    end
    if (rd_addr == CTRL_OFF) begin
      rd_mux = '0;
      rd_mux[EN_POS]  = en_q;
      rd_mux[ACT_POS] = act_q;
    end
  end

  assign rd_data = rd_en ? rd_mux : '0;
  assign brk_irq = act_q;

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [RAW-1:0]    wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [RAW-1:0]    rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_valid,
  input logic [ADDR_W-1:0] tgt,
  input logic              en,
  input logic              irq
);

  localparam logic [RAW-1:0] CTRL_OFF = RAW'(ADDR_W / DATA_W);
  localparam logic [RAW-1:0] LAST_OFF = '1;

  logic hw_set;
  logic sw_set;
  logic sw_clr;

  assign hw_set = en && cpu_valid && (cpu_addr == tgt);
  assign sw_set = wr_en && (wr_addr == CTRL_OFF) && wr_data[DATA_W-2];
  assign sw_clr = wr_en && (wr_addr == CTRL_OFF) && !wr_data[DATA_W-2];

  // R4 R10
  hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> irq);

  // R8
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> irq);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sw_clr) |=> irq);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && sw_clr && !hw_set) |=> !irq);

  // R5 R6 R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !hw_set && !sw_set) |=> !irq);

  // R3
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == CTRL_OFF) |-> (rd_data[DATA_W-3:0] == '0));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LAST_OFF) |-> (rd_data == '0));

  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind brk_unit brk_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW(RAW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .cpu_addr (cpu_addr),
  .cpu_valid(cpu_valid),
  .tgt      (tgt_addr),
  .en       (en_q),
  .irq      (brk_irq)
);

// File: tb/brk_unit_tb.sv
module brk_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] cpu_addr;
  logic        cpu_valid;
  logic        brk_irq;

  int n_chk  = 0;
  int n_fail = 0;

  brk_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cpu_addr (cpu_addr),
    .cpu_valid(cpu_valid),
    .brk_irq  (brk_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write: driven at a falling edge, registered at the next rising edge
  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Read: combinational, sampled 2 ns after the falling edge
  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #2;
    v = rd_data;
    rd_en = 1'b0;
  endtask

  // One bus cycle; irq is sampled one rising edge later
  task automatic bus(input logic [15:0] a, input logic v);
    @(negedge clk);
    cpu_addr = a; cpu_valid = v;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic set_tgt(input logic [15:0] t);
    reg_wr(2'd0, t[15:8]);
    reg_wr(2'd1, t[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] tgts [5];
    tgts[0] = 16'h0000; tgts[1] = 16'hFFFF; tgts[2] = 16'hA55A;
    tgts[3] = 16'h1234; tgts[4] = 16'h8001;

    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0; cpu_addr = '0; cpu_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk("R1 reset read", 16'(v), 16'h0);
    end
    chk("R1 reset irq", 16'(brk_irq), 16'h0);

    // R2: exhaustive byte sweep with complementary low byte
    for (int d = 0; d < 256; d++) begin
      reg_wr(2'd0, 8'(d));
      reg_wr(2'd1, 8'(255 - d));
      reg_rd(2'd0, v);
      chk("R2 high byte", 16'(v), 16'(d));
      reg_rd(2'd1, v);
      chk("R2 low byte", 16'(v), 16'(255 - d));
    end

    // R13: idle read strobe gives zero (high byte holds 0xFF)
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 2'd0;
    #2;
    chk("R13 idle read", 16'(rd_data), 16'h0);

    // R3: control layout; reserved bits read zero
    reg_wr(2'd2, 8'h3F);
    reg_rd(2'd2, v);
    chk("R3 reserved bits", 16'(v), 16'h00);
    reg_wr(2'd2, 8'hBF);
    reg_rd(2'd2, v);
    chk("R3 arm bit", 16'(v), 16'h80);

    // R8, R12: software set
    reg_wr(2'd2, 8'hC0);
    chk("R8 sw set irq", 16'(brk_irq), 16'h1);
    reg_rd(2'd2, v);
    chk("R8 R12 ctrl read", 16'(v), 16'hC0);

    // R9: software clear
    reg_wr(2'd2, 8'h80);
    chk("R9 sw clear irq", 16'(brk_irq), 16'h0);
    reg_rd(2'd2, v);
    chk("R9 R12 ctrl read", 16'(v), 16'h80);

    // Match sweep over several targets
    for (int t = 0; t < 5; t++) begin
      set_tgt(tgts[t]);
      reg_wr(2'd2, 8'h80);
      for (int b = 0; b < 16; b++) begin
        bus(tgts[t] ^ (16'h1 << b), 1'b1);
        chk("R7 single-bit mismatch", 16'(brk_irq), 16'h0);
      end
      bus(tgts[t], 1'b0);
      chk("R6 valid low", 16'(brk_irq), 16'h0);
      reg_wr(2'd2, 8'h00);
      bus(tgts[t], 1'b1);
      chk("R5 disarmed match", 16'(brk_irq), 16'h0);
      reg_rd(2'd2, v);
      chk("R5 ctrl read", 16'(v), 16'h00);
      reg_wr(2'd2, 8'h80);
      bus(tgts[t], 1'b1);
      chk("R4 armed match irq", 16'(brk_irq), 16'h1);
      reg_rd(2'd2, v);
      chk("R4 R12 ctrl read", 16'(v), 16'hC0);
      bus(tgts[t] ^ 16'h0001, 1'b1);
      chk("R9 sticky", 16'(brk_irq), 16'h1);
      reg_wr(2'd2, 8'h80);
      chk("R9 clear after match", 16'(brk_irq), 16'h0);
    end

    // R10: match and clear on the same cycle (target is 0x8001, armed)
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_valid = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h80;
    @(negedge clk);
    cpu_valid = 1'b0; wr_en = 1'b0;
    chk("R10 set wins", 16'(brk_irq), 16'h1);

    // R11: unmapped offset
    reg_wr(2'd3, 8'hFF);
    reg_rd(2'd3, v);
    chk("R11 unmapped read", 16'(v), 16'h00);
    chk("R11 irq unchanged", 16'(brk_irq), 16'h1);
    reg_rd(2'd0, v);
    chk("R11 high byte unchanged", 16'(v), 16'h80);
    reg_rd(2'd1, v);
    chk("R11 low byte unchanged", 16'(v), 16'h01);
    reg_rd(2'd2, v);
    chk("R11 ctrl unchanged", 16'(v), 16'hC0);
    reg_wr(2'd3, 8'h00);
    chk("R11 irq after zero write", 16'(brk_irq), 16'h1);

    reg_wr(2'd2, 8'h00);
    chk("R9 final clear", 16'(brk_irq), 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule